// File: doc/BRIEF.md
# Input Pulse Interval Capture Timer

This block is one timer channel that measures the time between valid edges on an input pin. Software launches the channel with a start pulse. From then on a counter of `CNT_W` bits (16 by default) advances once per active count tick. The tick comes from one of two prescaled clock enables, chosen by a select input. Each valid pin edge, or a start pulse while the channel is already running, copies the count into a capture register and restarts the counter from zero. The same event raises a one-cycle interrupt pulse.

An overflow flag is re-evaluated at every capture. It shows whether the counter wrapped at least once during the period just measured. Software rebuilds the interval in ticks as `2^CNT_W * ovf_flag + cap_data + 1`. That result is only exact when the counter wrapped at most once. The pin is resynchronized before edge detection, so each measurement carries an error of up to one operating clock.

A stop pulse halts counting and masks captures until the next start.

Top module: `pulse_interval_capture`

## Requirements
- R1: After reset `cap_data` is 0, `ovf_flag` is 0, `irq` is 0 and the channel is stopped: pin edges raise no interrupt.
- R2: A start pulse on a stopped channel clears the counter and starts it without a capture or interrupt. After that, the counter increments by one on every clock where the selected tick is high.
- R3: A valid pin edge on a running channel loads `cap_data` with the current count, restarts the counter at 0 and drives `irq` high for exactly one cycle. With a tick every clock, two valid edges D clocks apart capture D-1.
- R4: At each capture, `ovf_flag` becomes 1 if the counter wrapped from all-ones to 0 since the previous capture or start, and 0 otherwise. Two or more wraps also give 1.
- R5: A tick that coincides with the capture is not counted. A wrap on the tick just before the capture is counted. With a tick every clock, a period of 2^CNT_W clocks gives count all-ones with flag 0, and one clock more gives count 0 with flag 1.
- R6: A start pulse while the channel is running acts as a capture, with the same effect as a valid pin edge.
- R7: `edge_sel` picks the valid edge: 00 rising only, 01 falling only, 10 and 11 both. An edge not selected causes no capture and no interrupt.
- R8: The pin goes through a two-stage synchronizer. A pin change driven before clock edge 1 raises `irq` right after clock edge 3.
- R9: `cke_sel` = 0 counts on `cke_src0`, and `cke_sel` = 1 counts on `cke_src1`. The source not selected has no effect on the count.
- R10: A stop pulse halts the counter and masks all captures. Stop wins over a start in the same cycle. A later start restarts the count from 0 without an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| rst | input | 1 | Synchronous active-high reset |
| tin | input | 1 | Measured pulse input, asynchronous |
| cke_src0 | input | 1 | Count enable source 0 |
| cke_src1 | input | 1 | Count enable source 1 |
| cke_sel | input | 1 | Count enable select (0: source 0, 1: source 1) |
| sw_start | input | 1 | Start pulse; a capture trigger while running |
| sw_stop | input | 1 | Stop pulse |
| edge_sel | input | 2 | Valid edge select |
| cap_data | output | CNT_W | Captured count |
| ovf_flag | output | 1 | Wrap status of the last captured period |
| irq | output | 1 | One-cycle capture interrupt |

## Verification
The bench aims at the wrap boundary from both sides. A design that counted the coinciding tick, or compared against the live count instead of the registered tracker, would report the all-ones period as overflowed, or the period one clock longer as not overflowed. Chained captures check that the tracker is cleared after each capture: a stale tracker would flag a short period that follows a long one. The simultaneous start-and-stop case and edges seen while stopped catch a design that lets start win or leaves captures unmasked. Exact interrupt latency and ignored-edge windows catch a missing synchronizer stage or a wrong edge polarity decode.

// File: rtl/pic_pkg.sv
`timescale 1ns/1ps
package pic_pkg;
  // Valid edge selection codes seen on edge_sel
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/pic_edge_det.sv
`timescale 1ns/1ps
module pic_edge_det
  import pic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);
  // smp_q[SYNC_STAGES-1] is the synchronized level, smp_q[SYNC_STAGES] its history
  logic [SYNC_STAGES:0] smp_q;
  logic cur_lvl, prev_lvl, rise, fall;
  edge_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) smp_q <= '0;
    else     smp_q <= {smp_q[SYNC_STAGES-1:0], pin};
  end

  assign cur_lvl  = smp_q[SYNC_STAGES-1];
  assign prev_lvl = smp_q[SYNC_STAGES];
  assign rise     = cur_lvl & ~prev_lvl;
  assign fall     = ~cur_lvl & prev_lvl;

  always_comb begin
    mode = edge_mode_e'(edge_sel);
    case (mode)
      EDGE_RISE: edge_hit = rise;
      EDGE_FALL: edge_hit = fall;
      default:   edge_hit = rise | fall;
    endcase
  end
endmodule

// File: rtl/pic_tick_sel.sv
`timescale 1ns/1ps
module pic_tick_sel #(
  parameter int N_SRC = 2,
  parameter int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = src[i] && (sel == SEL_W'(i));
  end

  assign tick = |hit;
endmodule

// File: rtl/pic_core.sv
`timescale 1ns/1ps
module pic_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             trig_edge,
  input  logic             start,
  input  logic             stop,
  output logic [CNT_W-1:0] cap_q,
  output logic             ovf_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             run_q;
  logic             trk_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_launch, do_cap, do_step;

  // stop overrides everything; start on an idle channel only launches
  assign do_launch = start && !stop && !run_q;
  assign do_cap    = run_q && !stop && (trig_edge || start);
  assign do_step   = run_q && !stop && !do_cap && tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      trk_q <= 1'b0;
      cnt_q <= '0;
      cap_q <= '0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (stop) begin
        run_q <= 1'b0;
      end else if (do_launch) begin
        run_q <= 1'b1;
        cnt_q <= '0;
        trk_q <= 1'b0;
      end else if (do_cap) begin
        cap_q <= cnt_q;
        ovf_q <= trk_q;
        cnt_q <= '0;
        trk_q <= 1'b0;
        irq_q <= 1'b1;
      end else if (do_step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_MAX) trk_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pulse_interval_capture.sv
`timescale 1ns/1ps
module pulse_interval_capture #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tin,
  input  logic             cke_src0,
  input  logic             cke_src1,
  input  logic             cke_sel,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic [1:0]       edge_sel,
  output logic [CNT_W-1:0] cap_data,
  output logic             ovf_flag,
  output logic             irq
);
  localparam int N_SRC = 2;

  logic edge_hit;
  logic tick;

  pic_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .pin      (tin),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  pic_tick_sel #(.N_SRC(N_SRC)) u_tick (
    .src  ({cke_src1, cke_src0}),
    .sel  (cke_sel),
    .tick (tick)
  );

  pic_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .trig_edge (edge_hit),
    .start     (sw_start),
    .stop      (sw_stop),
    .cap_q     (cap_data),
    .ovf_q     (ovf_flag),
    .irq_q     (irq)
  );
endmodule

// File: rtl/pic_core_chk.sv
`timescale 1ns/1ps
module pic_core_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             trig_edge,
  input logic             start,
  input logic             stop,
  input logic             run_q,
  input logic             trk_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             ovf_q,
  input logic             irq_q
);
  // R2
  launch_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !stop && !run_q) |=> (run_q && cnt_q == '0 && !irq_q));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !start && !stop && !trig_edge) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3
  cap_value_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (cap_q == $past(cnt_q) && cnt_q == '0));

  // R4
  ovf_load_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ovf_q == $past(trk_q)));

  // R4
  wrap_track_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !start && !stop && !trig_edge && cnt_q == '1) |=> trk_q);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !irq_q);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !start) |=> $stable(cnt_q));

  // R10
  stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> (!run_q && !irq_q));
endmodule

bind pic_core pic_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .trig_edge (trig_edge),
  .start     (start),
  .stop      (stop),
  .run_q     (run_q),
  .trk_q     (trk_q),
  .cnt_q     (cnt_q),
  .cap_q     (cap_q),
  .ovf_q     (ovf_q),
  .irq_q     (irq_q)
);

// File: tb/pulse_interval_capture_tb.sv
`timescale 1ns/1ps
module pulse_interval_capture_tb;
  localparam int W    = 12;
  localparam int FULL = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tin = 1'b0;
  logic         cke0 = 1'b1;
  logic         cke1 = 1'b0;
  logic         cke_sel = 1'b0;
  logic         sw_start = 1'b0;
  logic         sw_stop = 1'b0;
  logic [1:0]   edge_sel = 2'b00;
  logic [W-1:0] cap_data;
  logic         ovf_flag;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pulse_interval_capture #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .tin      (tin),
    .cke_src0 (cke0),
    .cke_src1 (cke1),
    .cke_sel  (cke_sel),
    .sw_start (sw_start),
    .sw_stop  (sw_stop),
    .edge_sel (edge_sel),
    .cap_data (cap_data),
    .ovf_flag (ovf_flag),
    .irq      (irq)
  );

  task automatic chk(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // called just after a negedge; the pulse is seen by the next posedge
  task automatic pulse_start();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic pulse_stop();
    sw_stop = 1'b1;
    @(negedge clk);
    sw_stop = 1'b0;
  endtask

  task automatic watch(int n, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq) hits++;
    end
  endtask

  task automatic t_reset();
    int hits;
    chk("R1 cap after reset", cap_data, 0);
    chk("R1 ovf after reset", ovf_flag, 0);
    chk("R1 irq after reset", irq, 0);
    edge_sel = 2'b10;
    tin = 1'b1;
    watch(6, hits);
    tin = 1'b0;
    tick_n(4);
    chk("R1 idle ignores pin", hits, 0);
  endtask

  // software-triggered period of k clocks, tick every clock
  task automatic t_soft(int k, string tag);
    pulse_stop();
    cke_sel = 1'b0; cke0 = 1'b1;
    pulse_start();
    chk({tag, " launch irq"}, irq, 0);
    tick_n(k);
    pulse_start();
    chk({tag, " irq"}, irq, 1);
    chk({tag, " cap"}, cap_data, k % FULL);
    chk({tag, " ovf"}, ovf_flag, (k >= FULL) ? 1 : 0);
    tick_n(1);
    chk({tag, " irq one cycle"}, irq, 0);
  endtask

  // R4: tracker cleared after a capture that saw a wrap
  task automatic t_chain();
    pulse_stop();
    cke_sel = 1'b0; cke0 = 1'b1;
    pulse_start();
    tick_n(FULL + 2);
    pulse_start();
    chk("R4 long cap", cap_data, 2);
    chk("R4 long ovf", ovf_flag, 1);
    tick_n(6);
    pulse_start();
    chk("R4 short cap", cap_data, 6);
    chk("R4 short ovf cleared", ovf_flag, 0);
  endtask

  // R7/R8/R3: one selected polarity, opposite edge in between is ignored
  task automatic t_sel(logic [1:0] mode, logic lvl, int d, string tag);
    int hits;
    pulse_stop();
    edge_sel = mode;
    tin = ~lvl;
    tick_n(4);
    pulse_start();
    tin = lvl;
    tick_n(2);
    chk("R8 no irq before third edge", irq, 0);
    tick_n(1);
    chk("R8 irq at third edge", irq, 1);
    tick_n(2);
    tin = ~lvl;
    watch(d - 5, hits);
    chk({tag, " ignored edge"}, hits, 0);
    tin = lvl;
    tick_n(3);
    chk({tag, " R3 irq"}, irq, 1);
    chk({tag, " R3 cap"}, cap_data, d - 1);
  endtask

  task automatic t_both(logic [1:0] mode, int d);
    pulse_stop();
    edge_sel = mode;
    tick_n(4);
    pulse_start();
    tin = ~tin;
    tick_n(3);
    chk("R7 both first edge irq", irq, 1);
    tick_n(d - 3);
    tin = ~tin;
    tick_n(3);
    chk("R7 both second edge irq", irq, 1);
    chk("R7 both cap", cap_data, d - 1);
  endtask

  // R9: count source selection
  task automatic t_ticksel();
    pulse_stop();
    cke_sel = 1'b1; cke0 = 1'b1; cke1 = 1'b0;
    pulse_start();
    for (int i = 0; i < 9; i++) begin
      cke1 = 1'b1; tick_n(1);
      cke1 = 1'b0; tick_n(1);
    end
    pulse_start();
    chk("R9 source 1 count", cap_data, 9);
    pulse_stop();
    cke_sel = 1'b0; cke0 = 1'b0; cke1 = 1'b1;
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      cke0 = 1'b1; tick_n(1);
      cke0 = 1'b0; tick_n(2);
    end
    pulse_start();
    chk("R9 source 0 count", cap_data, 5);
    cke0 = 1'b1; cke1 = 1'b0;
  endtask

  // R10: stop behaviour
  task automatic t_stop();
    int hits;
    logic [W-1:0] held;
    pulse_stop();
    cke_sel = 1'b0; cke0 = 1'b1;
    edge_sel = 2'b10;
    pulse_start();
    tick_n(10);
    pulse_stop();
    held = cap_data;
    tin = ~tin;
    watch(6, hits);
    chk("R10 stopped edge masked", hits, 0);
    chk("R10 cap held", cap_data, held);
    sw_start = 1'b1; sw_stop = 1'b1;
    tick_n(1);
    sw_start = 1'b0; sw_stop = 1'b0;
    tin = ~tin;
    watch(6, hits);
    chk("R10 stop wins over start", hits, 0);
    pulse_start();
    chk("R10 restart no irq", irq, 0);
    tick_n(5);
    pulse_start();
    chk("R10 restart from zero", cap_data, 5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick_n(1);
    t_reset();
    t_soft(25, "R6");
    t_soft(FULL - 1, "R5 below wrap");
    t_soft(FULL, "R5 at wrap");
    t_soft(2 * FULL + 3, "R4 double wrap");
    t_chain();
    t_sel(2'b00, 1'b1, 40, "R7 rising");
    t_sel(2'b01, 1'b0, 33, "R7 falling");
    t_both(2'b10, 21);
    t_both(2'b11, 17);
    t_ticksel();
    t_stop();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule